// File: doc/BRIEF.md
# Debug Entry Cause Status Register

This block keeps the record of why a processor core stopped in its halted debug state, and reports what the core is doing at any moment. Three kinds of debug-entry request arrive as inputs: a software debug instruction (unconditional, or conditional with its condition true), a memory breakpoint match, and a trace counter at zero while tracing is switched on. On the cycle the core's debug indication first goes high, the block latches one flag per cause present. The flags then hold for the whole debug session and clear when the core leaves debug.

Alongside the flags, a two-bit core state code is produced from the core's debug, bus-wait and wait/stop indications. The cause flags and the state code form one read-only status word, returned on a registered read port. The state code is also passed through a synchronizer into the scan clock domain. There it becomes part of the capture value of a scan instruction shift register, so a debugger can poll the core state while the core clock is stopped. The breakpoint comparators, the trace counter and the test access port controller are outside the block and appear only as inputs.

Top module: `dbg_cause_stat`

## Requirements
- R1: Bit 2 of the status word (software-debug cause) becomes 1 when `evt_sw_debug` is high on the debug entry cycle. The entry cycle is the first cycle with `core_in_debug` high after it was low or after reset.
- R2: Bit 3 (memory-breakpoint cause) becomes 1 when `evt_mem_bp` is high on the entry cycle.
- R3: Bit 4 (trace cause) becomes 1 only when `trace_cnt_zero` and `trace_enable` are both high on the entry cycle.
- R4: When several causes are present on the entry cycle, every matching flag is set together.
- R5: While `core_in_debug` stays high after the entry cycle, cause inputs are ignored and the flags hold their value.
- R6: On the first clock edge with `core_in_debug` low, all cause flags clear to 0.
- R7: Bit 5 is reserved and always reads 0. Bits 1:0 always read 0.
- R8: Bits 7:6 hold the core state code, chosen by fixed priority: 11 when in debug, otherwise 10 when waiting for the bus, otherwise 01 when in wait or stop, otherwise 00 (executing). This code explains a pending debug request that has not yet been entered.
- R9: A clock edge with `rd_en` high loads the status word into `rd_data`. The word reflects the inputs from one edge earlier. While `rd_en` is low, `rd_data` holds.
- R10: A synchronous active-high `rst` clears the cause flags, sets the state code to 00 and clears `rd_data`. After reset, a still-high `core_in_debug` counts as a new entry.
- R11: A `tck` edge with `ir_capture` high loads the instruction register with bits 1:0 = 01, the top two bits = the state code after a two-stage synchronizer, and all other bits 0. A `tck` edge with `ir_shift` high shifts the register one place toward bit 0, with `tdi` entering the top bit. `tdo` always shows bit 0.
- R12: The scan capture and shift work while `clk` is stopped, and return the last registered state code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset, core domain |
| core_in_debug | input | 1 | Core is in halted debug state |
| core_in_waitstop | input | 1 | Core is in wait or stop |
| core_bus_wait | input | 1 | Core is stalled waiting for the bus |
| evt_sw_debug | input | 1 | Debug entry request from a software debug instruction |
| evt_mem_bp | input | 1 | Debug entry request from a memory breakpoint match |
| trace_cnt_zero | input | 1 | Trace counter has reached zero |
| trace_enable | input | 1 | Trace mode is enabled |
| rd_en | input | 1 | Read strobe for the status word |
| rd_data | output | 8 | Registered status word |
| tck | input | 1 | Scan clock |
| tap_rst | input | 1 | Synchronous active-high reset, scan domain |
| ir_capture | input | 1 | Load the capture value into the instruction register |
| ir_shift | input | 1 | Shift the instruction register by one place |
| tdi | input | 1 | Scan serial input |
| tdo | output | 1 | Scan serial output (register bit 0) |

## Verification
The assertions assume that the cause inputs matter only on the entry cycle. They also assume that `ir_capture` and `ir_shift` are never high in the same `tck` cycle, and that the state code is held for at least two `tck` edges before a capture. The stimulus keeps to these rules. It drives cause pulses only together with a rising debug indication, or on purpose during an open session. It runs two idle `tck` pulses before every capture, and it never raises capture and shift together. Both the cause combinations and the state indications are swept in full, and each expected word is built by arithmetic from the bit positions in the requirements.

// File: rtl/dbg_stat_pkg.sv
`timescale 1ns/1ps
package dbg_stat_pkg;

  // Core state code; the numeric values are part of the register contract.
  typedef enum logic [1:0] {
    CS_EXEC     = 2'b00,
    CS_WAITSTOP = 2'b01,
    CS_BUSWAIT  = 2'b10,
    CS_DEBUG    = 2'b11
  } core_state_e;

  // Latched cause flags, lowest field maps to the lowest status bit.
  typedef struct packed {
    logic trace;
    logic membp;
    logic swdbg;
  } cause_t;

  localparam int STAT_W     = 8;
  localparam int CAUSE_LSB  = 2;
  localparam int CAUSE_W    = $bits(cause_t);
  localparam int RSV_BIT    = CAUSE_LSB + CAUSE_W;
  localparam int STATE_LSB  = RSV_BIT + 1;
  localparam int STATE_W    = 2;

endpackage

// File: rtl/dbg_cause_latch.sv
`timescale 1ns/1ps
module dbg_cause_latch
  import dbg_stat_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   in_debug,
  input  logic   sw_evt,
  input  logic   bp_evt,
  input  logic   trc_zero,
  input  logic   trc_en,
  output cause_t flags_o
);

  logic   sess_q;
  cause_t flags_q;
  cause_t entry_c;
  logic   entry_c_v;

  assign entry_c_v = in_debug && !sess_q;

  always_comb begin
    entry_c       = '0;
    entry_c.swdbg = sw_evt;
    entry_c.membp = bp_evt;
    entry_c.trace = trc_zero && trc_en;
  end

  // Session tracker: high from the cycle after entry until exit.
  always_ff @(posedge clk) begin
    if (rst) sess_q <= 1'b0;
    else     sess_q <= in_debug;
  end

  always_ff @(posedge clk) begin
    if (rst)            flags_q <= '0;
    else if (!in_debug) flags_q <= '0;
    else if (entry_c_v) flags_q <= entry_c;
  end

  assign flags_o = flags_q;

  // R1: software cause captured on entry
  a_r1_sw_entry: assert property (@(posedge clk) disable iff (rst)
    (in_debug && !sess_q && sw_evt) |=> flags_o.swdbg);

  // R3: trace cause requires both terms
  a_r3_trace_gate: assert property (@(posedge clk) disable iff (rst)
    (in_debug && !sess_q && !(trc_zero && trc_en)) |=> !flags_o.trace);

  // R5: flags frozen during an open session
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (sess_q && in_debug) |=> $stable(flags_o));

  // R6: flags clear after exit
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (!in_debug) |=> (flags_o == '0));

endmodule

// File: rtl/dbg_state_enc.sv
`timescale 1ns/1ps
module dbg_state_enc
  import dbg_stat_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_debug,
  input  logic        in_buswait,
  input  logic        in_waitstop,
  output core_state_e state_o
);

  core_state_e state_c;
  core_state_e state_q;

  // Fixed priority: debug, bus wait, wait/stop, executing.
  always_comb begin
    if (in_debug)         state_c = CS_DEBUG;
    else if (in_buswait)  state_c = CS_BUSWAIT;
    else if (in_waitstop) state_c = CS_WAITSTOP;
    else                  state_c = CS_EXEC;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= CS_EXEC;
    else     state_q <= state_c;
  end

  assign state_o = state_q;

  // R8: debug wins over every other indication
  a_r8_debug_prio: assert property (@(posedge clk) disable iff (rst)
    in_debug |=> (state_o == CS_DEBUG));

  // R8: bus wait beats wait/stop when not in debug
  a_r8_bus_prio: assert property (@(posedge clk) disable iff (rst)
    (!in_debug && in_buswait) |=> (state_o == CS_BUSWAIT));

endmodule

// File: rtl/dbg_ir_capture.sv
`timescale 1ns/1ps
module dbg_ir_capture
  import dbg_stat_pkg::*;
#(
  parameter int IR_LEN      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               tck,
  input  logic               tap_rst,
  input  logic [STATE_W-1:0] state_i,
  input  logic               capture,
  input  logic               shift,
  input  logic               tdi,
  output logic               tdo
);

  localparam int TOP = IR_LEN - 1;

  logic [STATE_W-1:0] sync_q [SYNC_STAGES];
  logic [IR_LEN-1:0]  cap_val;
  logic [IR_LEN-1:0]  ir_q;

  // Synchronizer chain into the scan clock domain.
  always_ff @(posedge tck) begin
    if (tap_rst) sync_q[0] <= '0;
    else         sync_q[0] <= state_i;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge tck) begin
      if (tap_rst) sync_q[s] <= '0;
      else         sync_q[s] <= sync_q[s-1];
    end
  end

  always_comb begin
    cap_val                 = '0;
    cap_val[1:0]            = 2'b01;
    cap_val[TOP -: STATE_W] = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge tck) begin
    if (tap_rst)      ir_q <= '0;
    else if (capture) ir_q <= cap_val;
    else if (shift)   ir_q <= {tdi, ir_q[TOP:1]};
  end

  assign tdo = ir_q[0];

  // R11: capture loads the fixed low pattern
  a_r11_cap_low: assert property (@(posedge tck) disable iff (tap_rst)
    capture |=> (ir_q[1:0] == 2'b01));

  // R11: serial input lands in the top bit
  a_r11_shift_in: assert property (@(posedge tck) disable iff (tap_rst)
    (shift && !capture) |=> (ir_q[TOP] == $past(tdi)));

endmodule

// File: rtl/dbg_cause_stat.sv
`timescale 1ns/1ps
module dbg_cause_stat
  import dbg_stat_pkg::*;
#(
  parameter int IR_LEN      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_in_debug,
  input  logic              core_in_waitstop,
  input  logic              core_bus_wait,
  input  logic              evt_sw_debug,
  input  logic              evt_mem_bp,
  input  logic              trace_cnt_zero,
  input  logic              trace_enable,
  input  logic              rd_en,
  output logic [STAT_W-1:0] rd_data,
  input  logic              tck,
  input  logic              tap_rst,
  input  logic              ir_capture,
  input  logic              ir_shift,
  input  logic              tdi,
  output logic              tdo
);

  cause_t            flags;
  core_state_e       state;
  logic [STAT_W-1:0] word_c;
  logic [STAT_W-1:0] rd_q;

  dbg_cause_latch u_cause (
    .clk      (clk),
    .rst      (rst),
    .in_debug (core_in_debug),
    .sw_evt   (evt_sw_debug),
    .bp_evt   (evt_mem_bp),
    .trc_zero (trace_cnt_zero),
    .trc_en   (trace_enable),
    .flags_o  (flags)
  );

  dbg_state_enc u_state (
    .clk         (clk),
    .rst         (rst),
    .in_debug    (core_in_debug),
    .in_buswait  (core_bus_wait),
    .in_waitstop (core_in_waitstop),
    .state_o     (state)
  );

  dbg_ir_capture #(
    .IR_LEN      (IR_LEN),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ir (
    .tck     (tck),
    .tap_rst (tap_rst),
    .state_i (state),
    .capture (ir_capture),
    .shift   (ir_shift),
    .tdi     (tdi),
    .tdo     (tdo)
  );

  // Status word: reserved and low bits tied to zero.
  always_comb begin
    word_c                              = '0;
    word_c[CAUSE_LSB +: CAUSE_W]        = flags;
    word_c[STATE_LSB +: STATE_W]        = state;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= word_c;
  end

  assign rd_data = rd_q;

  // R7: reserved and low bits never set
  always_ff @(posedge clk) begin
    if (!rst) begin
      a_r7_zero_bits: assert (rd_data[RSV_BIT] == 1'b0 && rd_data[1:0] == 2'b00);
    end
  end

  // R9: read data holds without a strobe
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

endmodule

// File: tb/dbg_cause_stat_tb.sv
`timescale 1ns/1ps
module dbg_cause_stat_tb_top;

  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       rst = 1'b1;
  logic       core_in_debug = 0, core_in_waitstop = 0, core_bus_wait = 0;
  logic       evt_sw_debug = 0, evt_mem_bp = 0, trace_cnt_zero = 0, trace_enable = 0;
  logic       rd_en = 1'b1;
  logic [7:0] rd_data;
  logic       tck = 1'b0, tap_rst = 1'b1, ir_capture = 0, ir_shift = 0, tdi = 0;
  logic       tdo;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  dbg_cause_stat dut_i (
    .clk(clk), .rst(rst),
    .core_in_debug(core_in_debug), .core_in_waitstop(core_in_waitstop),
    .core_bus_wait(core_bus_wait), .evt_sw_debug(evt_sw_debug),
    .evt_mem_bp(evt_mem_bp), .trace_cnt_zero(trace_cnt_zero),
    .trace_enable(trace_enable), .rd_en(rd_en), .rd_data(rd_data),
    .tck(tck), .tap_rst(tap_rst), .ir_capture(ir_capture),
    .ir_shift(ir_shift), .tdi(tdi), .tdo(tdo)
  );

  always begin
    #2.5;
    if (clk_run) clk = ~clk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tpulse();
    #5 tck = 1'b1;
    #5 tck = 1'b0;
  endtask

  function automatic logic [7:0] word(input logic [1:0] code, input logic [2:0] fl);
    return {code, 1'b0, fl, 2'b00};
  endfunction

  // Capture then shift out LSB first, returning the captured value.
  task automatic scan_read(output logic [3:0] v);
    tpulse(); tpulse();
    ir_capture = 1'b1; tpulse(); ir_capture = 1'b0;
    for (int i = 0; i < 4; i++) begin
      v[i] = tdo;
      tdi = i[0];
      ir_shift = 1'b1; tpulse(); ir_shift = 1'b0;
    end
  endtask

  initial begin
    logic [3:0] sv;
    logic [1:0] ec;
    logic [2:0] ef;
    // R10: reset state
    tpulse(); tpulse(); tap_rst = 1'b0;
    step(2);
    chk("R10 reset rd_data", rd_data, 8'h00);
    rst = 1'b0;
    step(2);
    chk("R10 idle after reset", rd_data, 8'h00);

    // R1..R6: full sweep of cause combinations
    for (int c = 0; c < 16; c++) begin
      evt_sw_debug = c[0]; evt_mem_bp = c[1];
      trace_cnt_zero = c[2]; trace_enable = c[3];
      core_in_debug = 1'b1;
      step(1);
      evt_sw_debug = 0; evt_mem_bp = 0; trace_cnt_zero = 0; trace_enable = 0;
      step(1);
      ef = {c[2] & c[3], c[1], c[0]};
      chk("R1 R2 R3 R4 entry flags", rd_data, word(2'b11, ef));
      evt_sw_debug = 1; evt_mem_bp = 1; trace_cnt_zero = 1; trace_enable = 1;
      step(2);
      chk("R5 later causes ignored", rd_data, word(2'b11, ef));
      evt_sw_debug = 0; evt_mem_bp = 0; trace_cnt_zero = 0; trace_enable = 0;
      core_in_debug = 1'b0;
      step(2);
      chk("R6 clear on exit", rd_data, word(2'b00, 3'b000));
    end

    // R8: all state indication combinations, no causes
    for (int m = 0; m < 8; m++) begin
      core_in_debug = m[2]; core_bus_wait = m[1]; core_in_waitstop = m[0];
      step(2);
      ec = m[2] ? 2'b11 : m[1] ? 2'b10 : m[0] ? 2'b01 : 2'b00;
      chk("R8 state code", rd_data, word(ec, 3'b000));
      chk("R7 reserved bits zero", {rd_data[5], rd_data[1:0]}, 3'b000);
    end
    core_in_debug = 0; core_bus_wait = 0; core_in_waitstop = 0;
    step(2);

    // R9: read strobe gating
    rd_en = 1'b0;
    core_bus_wait = 1'b1;
    step(3);
    chk("R9 hold without rd_en", rd_data, word(2'b00, 3'b000));
    rd_en = 1'b1;
    step(1);
    chk("R9 load with rd_en", rd_data, word(2'b10, 3'b000));
    core_bus_wait = 1'b0;
    step(2);

    // R10: reset inside a session, debug still high
    core_in_debug = 1'b1; evt_mem_bp = 1'b1;
    step(1);
    evt_mem_bp = 1'b0;
    step(1);
    chk("R10 pre-reset session", rd_data, word(2'b11, 3'b010));
    rst = 1'b1;
    step(1);
    chk("R10 reset clears", rd_data, 8'h00);
    rst = 1'b0; evt_sw_debug = 1'b1;
    step(1);
    evt_sw_debug = 1'b0;
    step(1);
    chk("R10 new entry after reset", rd_data, word(2'b11, 3'b001));
    core_in_debug = 1'b0;
    step(2);

    // R11: scan capture for each state code
    for (int k = 0; k < 4; k++) begin
      core_in_debug = (k == 3); core_bus_wait = (k == 2); core_in_waitstop = (k == 1);
      step(2);
      scan_read(sv);
      chk("R11 capture value", sv, {k[1:0], 2'b01});
      for (int i = 0; i < 4; i++) begin
        sv[i] = tdo;
        ir_shift = 1'b1; tpulse(); ir_shift = 1'b0;
      end
      chk("R11 tdi path", sv, 4'b1010);
    end

    // R12: stop the core clock in wait/stop and poll over scan
    core_in_debug = 0; core_bus_wait = 0; core_in_waitstop = 1'b1;
    step(2);
    clk_run = 1'b0;
    core_in_waitstop = 1'b0;
    scan_read(sv);
    chk("R12 capture with clock stopped", sv, 4'b0101);
    scan_read(sv);
    chk("R12 second poll with clock stopped", sv, 4'b0101);
    clk_run = 1'b1;
    step(2);
    scan_read(sv);
    chk("R12 capture after restart", sv, 4'b0001);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule